// File: doc/BRIEF.md
# Page Program and Burst Read Sequencer

This block generates the control strobes for an embedded nonvolatile memory under serial test access. A separate serial controller shifts a 6-bit mode code, a start address and a data word into three chains. It also reports which chain is active. The sequencer watches the decoded mode, that chain state and the shift/load select line. Clock edges given while the select line is low are commands, and their meaning depends on the active chain.

In the page write modes, command edges do three things:
- An edge in the address state toggles the page-mode enable.
- An edge in the data state advances the address counter.
- An edge in the test state emits a one-cycle page-latch pulse.

In read mode, an edge in the data state emits a one-cycle capture strobe, and an edge in the address state advances the counter. A whole page burst can therefore run from a single loaded start address. The memory write enable is an active-low pin that passes straight through.

Top module: `nvm_page_seq`

## Requirements
- R1: Mode codes 2 (page write) and 4 (partial programming) enable the page functions. Code 3 (read) enables the read functions. Every other code, such as 0, 1, 5, 6, 7 and 8, makes command edges do nothing. The chain state input is one-hot: bit 0 is the test chain, bit 1 the address chain and bit 2 the data chain. A command edge is a rising clock edge with `shift_i` low.
- R2: In a page mode, a command edge in the address state inverts `page_en_o`. The first such edge sets it and the next one clears it.
- R3: In a page mode, a command edge in the data state increments `addr_o` by one. The new value is visible after that edge.
- R4: In a page mode, a command edge in the test state raises `page_latch_o` for exactly the one cycle that follows that edge.
- R5: In read mode, a command edge in the data state raises `capture_o` for exactly the one cycle that follows that edge.
- R6: In read mode, a command edge in the address state increments `addr_o` by one.
- R7: `mem_wen_no` always equals `wen_ni`, with no clock delay.
- R8: Between two toggles of `page_en_o`, at most PAGE_WORDS page-latch pulses (default 4) are produced. Any further test-state command edge gives no pulse.
- R9: A clock edge with `addr_load_i` high loads `addr_i` into the counter. If an increment falls on the same edge, the load wins. With no load and no increment, `addr_o` holds its value.
- R10: Reset (`rst_ni` low) clears `page_en_o`, `page_latch_o`, `capture_o` and `addr_o`. Any clock edge that sees a mode code other than 2 or 4 clears `page_en_o`.
- R11: The address counter wraps from 2^ADDR_W-1 (default 255) to 0.
- R12: Clock edges with `shift_i` high neither move the counter nor produce pulses or toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 6 | Decoded mode code from the test chain |
| chain_st_i | input | 3 | One-hot active chain: bit0 test, bit1 address, bit2 data |
| shift_i | input | 1 | Shift/load select; low marks a command edge |
| addr_load_i | input | 1 | Address chain has a newly loaded value |
| addr_i | input | ADDR_W | Address loaded from the address chain |
| wen_ni | input | 1 | External active-low write enable pin |
| page_en_o | output | 1 | Page-mode enable level |
| page_latch_o | output | 1 | One-cycle page buffer latch pulse |
| addr_o | output | ADDR_W | Current memory address |
| capture_o | output | 1 | One-cycle read data capture strobe |
| mem_wen_no | output | 1 | Active-low memory write enable |

## Verification
Two of the block's functions can meet in one cycle. A fresh address load can coincide with a command edge that would increment the counter, and a mode change can coincide with an address-state command edge that would toggle the page enable. The bench drives both collisions on purpose. It expects the loaded value to win over the increment, and it expects the clear from the mode change to win over the toggle. A behavioural model runs alongside the design and judges every output on every clock, so a wrong priority shows up in the cycle it occurs.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  localparam int MODE_W = 6;

  typedef enum logic [MODE_W-1:0] {
    MODE_CHIP_ERASE = 6'd0,
    MODE_CHIP_WRITE = 6'd1,
    MODE_PAGE_WRITE = 6'd2,
    MODE_READ       = 6'd3,
    MODE_PARTIAL    = 6'd4,
    MODE_MARGIN     = 6'd5,
    MODE_LOCK_READ  = 6'd6,
    MODE_LOCK_WRITE = 6'd7,
    MODE_HOT_BIAS   = 6'd8
  } nvm_mode_e;

  // one-hot chain state bit positions
  localparam int ST_TEST = 0;
  localparam int ST_ADDR = 1;
  localparam int ST_DATA = 2;
  localparam int ST_W    = 3;

  typedef struct packed {
    logic page_mode;
    logic read_mode;
    logic cmd_test;
    logic cmd_addr;
    logic cmd_data;
  } cmd_t;
endpackage

// File: rtl/nvm_seq_dec.sv
module nvm_seq_dec
  import nvm_seq_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ST_W-1:0]   chain_st_i,
  input  logic              shift_i,
  output cmd_t              cmd_o
);
  logic cmd_edge;
  assign cmd_edge = ~shift_i;

  always_comb begin
    cmd_o.page_mode = (mode_i == MODE_PAGE_WRITE) || (mode_i == MODE_PARTIAL);
    cmd_o.read_mode = (mode_i == MODE_READ);
    cmd_o.cmd_test  = cmd_edge & chain_st_i[ST_TEST];
    cmd_o.cmd_addr  = cmd_edge & chain_st_i[ST_ADDR];
    cmd_o.cmd_data  = cmd_edge & chain_st_i[ST_DATA];
  end
endmodule

// File: rtl/nvm_seq_addr.sv
module nvm_seq_addr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= addr_i;       // load wins over increment
    else if (inc_i)  cnt_q <= cnt_q + 1'b1; // wraps naturally
  end

  assign addr_o = cnt_q;

  AST_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(load_i) |-> addr_o == $past(addr_i)) else $error("load"); // R9
  AST_ADDR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(load_i) && $past(inc_i) |-> addr_o == ADDR_W'($past(addr_o) + 1'b1)) else $error("inc"); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(load_i) && !$past(inc_i) |-> $stable(addr_o)) else $error("hold"); // R9
endmodule

// File: rtl/nvm_seq_page.sv
module nvm_seq_page #(
  parameter int PAGE_WORDS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic page_mode_i,
  input  logic cmd_test_i,
  input  logic cmd_addr_i,
  output logic page_en_o,
  output logic latch_o
);
  localparam int CNT_W = $clog2(PAGE_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAGE_WORDS);

  logic             en_q, latch_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fire;

  assign fire = page_mode_i & cmd_test_i & (cnt_q < CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      cnt_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      latch_q <= fire;
      if (!page_mode_i) begin
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else if (cmd_addr_i) begin
        en_q  <= ~en_q;
        cnt_q <= '0;           // new burst window
      end else if (fire) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign page_en_o = en_q;
  assign latch_o   = latch_q;

  AST_PAGE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(page_mode_i) && $past(cmd_addr_i) |-> page_en_o != $past(page_en_o)) else $error("toggle"); // R2
  AST_PAGE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_mode_i |=> !page_en_o) else $error("clear"); // R10
  AST_LATCH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> $past(rst_ni) && $past(page_mode_i) && $past(cmd_test_i)) else $error("latch"); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX) else $error("overflow"); // R8
endmodule

// File: rtl/nvm_page_seq.sv
module nvm_page_seq
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        mode_i,
  input  logic [2:0]        chain_st_i,
  input  logic              shift_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wen_ni,
  output logic              page_en_o,
  output logic              page_latch_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              capture_o,
  output logic              mem_wen_no
);
  cmd_t cmd;
  logic inc;
  logic capture_q;

  nvm_seq_dec u_dec (
    .mode_i     (mode_i),
    .chain_st_i (chain_st_i),
    .shift_i    (shift_i),
    .cmd_o      (cmd)
  );

  assign inc = (cmd.page_mode & cmd.cmd_data) | (cmd.read_mode & cmd.cmd_addr);

  nvm_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (addr_load_i),
    .addr_i (addr_i),
    .inc_i  (inc),
    .addr_o (addr_o)
  );

  nvm_seq_page #(.PAGE_WORDS(PAGE_WORDS)) u_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .page_mode_i (cmd.page_mode),
    .cmd_test_i  (cmd.cmd_test),
    .cmd_addr_i  (cmd.cmd_addr),
    .page_en_o   (page_en_o),
    .latch_o     (page_latch_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) capture_q <= 1'b0;
    else         capture_q <= cmd.read_mode & cmd.cmd_data;
  end

  assign capture_o  = capture_q;
  assign mem_wen_no = wen_ni;

  AST_CAPTURE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> $past(rst_ni) && $past(mode_i) == MODE_READ && $past(chain_st_i[ST_DATA]) && !$past(shift_i)) else $error("cap"); // R5
  AST_SHIFT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(shift_i) |-> !capture_o && !page_latch_o) else $error("quiet"); // R12
  AST_WEN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wen_no == wen_ni) else $error("wen"); // R7
endmodule

// File: tb/sim_nvm_page_seq.sv
`timescale 1ns/1ps
module sim_nvm_page_seq;
  localparam int AW = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    mode = 6'd0;
  logic [2:0]    st = 3'b001;
  logic          shift = 1'b1;
  logic          load = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          wen_n = 1'b1;
  logic          page_en, latch, capture, mem_wen_n;
  logic [AW-1:0] addr;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int m_addr = 0, m_cnt = 0;
  bit m_en = 0, m_latch = 0, m_cap = 0;

  always #4 clk = ~clk; // 125 MHz

  nvm_page_seq #(.ADDR_W(AW), .PAGE_WORDS(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .chain_st_i(st), .shift_i(shift),
    .addr_load_i(load), .addr_i(addr_in), .wen_ni(wen_n),
    .page_en_o(page_en), .page_latch_o(latch), .addr_o(addr),
    .capture_o(capture), .mem_wen_no(mem_wen_n)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R10 page_en", int'(page_en), int'(m_en));
    chk("R4/R8 page_latch", int'(latch), int'(m_latch));
    chk("R5 capture", int'(capture), int'(m_cap));
    chk("R3/R6/R9/R11 addr", int'(addr), m_addr);
    chk("R7 mem_wen", int'(mem_wen_n), int'(wen_n));
  endtask

  // reference model for one rising edge, inputs held stable
  task automatic model_edge();
    bit wm, rd, cmd, t, a, d;
    wm  = (mode == 6'd2) || (mode == 6'd4);
    rd  = (mode == 6'd3);
    cmd = !shift;
    t = cmd && st[0]; a = cmd && st[1]; d = cmd && st[2];
    m_latch = wm && t && (m_cnt < PW);
    m_cap   = rd && d;
    if (load) m_addr = int'(addr_in);
    else if ((wm && d) || (rd && a)) m_addr = (m_addr + 1) % (1 << AW);
    if (!wm) begin m_en = 0; m_cnt = 0; end
    else if (a) begin m_en = !m_en; m_cnt = 0; end
    else if (m_latch) m_cnt++;
  endtask

  task automatic step(input logic [5:0] md, input logic [2:0] s, input logic sh,
                      input logic ld = 1'b0, input logic [AW-1:0] av = '0);
    mode = md; st = s; shift = sh; load = ld; addr_in = av;
    @(posedge clk);
    model_edge();
    #2;
    compare_all();
  endtask

  localparam logic [2:0] T = 3'b001, A = 3'b010, D = 3'b100;

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    compare_all();                      // R10 reset state
    @(negedge clk); rst_n = 1'b1;
    #1;

    // page write burst: R2 R3 R4 R8 R9
    step(6'd2, T, 1'b1);                // R12 shift edge idle
    step(6'd2, A, 1'b0);                // R2 page_en set
    step(6'd2, A, 1'b1, 1'b1, 8'h0F);   // R9 load start-1
    step(6'd2, D, 1'b0);                // R3 -> 0x10
    for (int i = 0; i < PW + 2; i++) begin
      step(6'd2, T, 1'b0);              // R4 latch / R8 limit
      step(6'd2, T, 1'b1);
      step(6'd2, A, 1'b1);              // R12 idle in address state
      step(6'd2, D, 1'b0);              // R3
    end
    step(6'd2, A, 1'b0);                // R2 clear
    step(6'd2, A, 1'b0);                // R2 set again, window reset
    step(6'd2, T, 1'b0);                // R8 latch allowed again
    step(6'd2, T, 1'b0);                // R4 back-to-back edges
    // collision: load and increment at same edge
    step(6'd2, D, 1'b0, 1'b1, 8'h40);   // R9 load wins
    // R11 wrap
    step(6'd4, A, 1'b1, 1'b1, 8'hFF);
    step(6'd4, D, 1'b0);                // R11 -> 0
    step(6'd4, D, 1'b1);                // R12 hold
    step(6'd4, T, 1'b0);                // R4 partial mode latch
    // collision: mode change with address command edge
    step(6'd3, A, 1'b0);                // R10 clear wins, R6 inc
    // read burst: R5 R6
    step(6'd3, A, 1'b1, 1'b1, 8'h20);
    step(6'd3, D, 1'b0);                // R5 capture
    step(6'd3, D, 1'b1);
    step(6'd3, T, 1'b0);                // R1 no effect in read test state
    step(6'd3, A, 1'b0);                // R6 inc
    step(6'd3, D, 1'b0);                // R5
    step(6'd3, D, 1'b0);                // R5 second pulse
    // other modes: R1 no effect
    for (int m = 0; m < 9; m++) begin
      if (m == 2 || m == 3 || m == 4) continue;
      step(6'(m), A, 1'b0);
      step(6'(m), D, 1'b0);
      step(6'(m), T, 1'b0);
    end
    // R7 pass-through
    wen_n = 1'b0; #1; chk("R7 mem_wen low", int'(mem_wen_n), 0);
    wen_n = 1'b1; #1; chk("R7 mem_wen high", int'(mem_wen_n), 1);
    // R10 async reset with page_en set
    step(6'd2, A, 1'b0);
    step(6'd2, T, 1'b0);
    #1; rst_n = 1'b0;
    m_en = 0; m_latch = 0; m_cap = 0; m_addr = 0; m_cnt = 0;
    #1; compare_all();                  // R10
    @(negedge clk); rst_n = 1'b1;
    step(6'd2, T, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule